// File: doc/BRIEF.md
# Timer Input Capture Unit

This block records the value of a free-running timer counter when a chosen transition appears on an external capture pin. The pin is asynchronous to the timer clock. It is resampled into the clock domain, and its edges are found on the resampled signal. A qualifying edge copies the counter into a capture register and raises a capture flag. The flag, gated by an enable bit, drives an interrupt request.

The register has a second use. When the timer uses it as its TOP (wrap) value, the capture pin is cut off entirely. The register then holds only what software writes into it. Software clears the flag by writing a one to it.

Top module: `icap_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, that edge clears `cap_reg` to 0, clears `cap_flag` to 0 and clears the stored previous pin sample to 0, so `cap_irq` is 0 afterwards.
- R2: With `edge_rise` = 1, a low-to-high change of `cap_pin` first sampled at clock edge N loads `cap_reg` with the `cnt_val` present at clock edge N+2. The extra two cycles come from the two-stage synchronizer and the edge detector.
- R3: With `edge_rise` = 0, a high-to-low change of `cap_pin` triggers the capture instead. An edge of the opposite polarity leaves `cap_reg` and `cap_flag` unchanged.
- R4: Each capture sets `cap_flag` at the same clock edge that loads `cap_reg`.
- R5: `cap_irq` is 1 exactly when `cap_flag` is 1 and `irq_en` is 1.
- R6: At an edge where `top_mode` is 1, no capture takes place. `cap_flag` is not set, and `cap_reg` changes only through a software write.
- R7: When `sw_wr_en` is 1, the next clock edge loads `sw_wr_data` into `cap_reg`. A capture at that same edge wins, and the counter value is stored instead.
- R8: When `flag_clr` is 1, the next clock edge clears `cap_flag`. A capture at that same edge wins, and the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_val | input | 16 | Current value of the free-running counter |
| cap_pin | input | 1 | Raw, asynchronous capture input |
| edge_rise | input | 1 | 1 selects a rising trigger edge, 0 a falling one |
| irq_en | input | 1 | Capture interrupt enable |
| top_mode | input | 1 | 1 when the capture register serves as counter TOP |
| sw_wr_en | input | 1 | Software write strobe for the capture register |
| sw_wr_data | input | 16 | Data for a software write |
| flag_clr | input | 1 | Write-one-to-clear strobe for the capture flag |
| cap_reg | output | 16 | Capture register |
| cap_flag | output | 1 | Capture flag |
| cap_irq | output | 1 | Capture interrupt request |

## Verification
A capture can land in the same clock edge as a software action: either a register write or a flag clear. Directed cases time the pin change so that its detected edge falls exactly two cycles later. The write strobe or the clear strobe is placed on that same edge. The outcome is judged by the stored counter value and a flag that stays set. Random stimulus then mixes all strobes, modes and pin activity, and every cycle is compared with a cycle-accurate reference model kept in the bench.

// File: rtl/icap_pkg.sv
// Package: shared types and defaults for the input capture unit.
// Assumes: nothing beyond a single timer clock domain.
package icap_pkg;
    localparam int unsigned ICAP_CNT_W   = 16;
    localparam int unsigned ICAP_STAGES  = 2;

    // Trigger polarity encoding as seen on the edge_rise input.
    typedef enum logic {
        POL_FALL = 1'b0,
        POL_RISE = 1'b1
    } icap_pol_e;

    // Returns 1 when the transition from prev to curr matches the polarity.
    function automatic logic icap_edge_match(icap_pol_e pol, logic prev, logic curr);
        return (pol == POL_RISE) ? (curr & ~prev) : (~curr & prev);
    endfunction
endpackage

// File: rtl/icap_sync.sv
// Module: icap_sync
// Resamples an asynchronous level into the clock domain with a flop chain.
// Assumes: STAGES >= 2; reset value of every stage is 0.
module icap_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the chain, one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/icap_edge.sv
// Module: icap_edge
// Finds the selected edge on a synchronized level and gates it with enable.
// Assumes: level_in is already in the clk domain; previous sample resets to 0.
module icap_edge
    import icap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    input  logic pol_rise,
    input  logic enable,
    output logic trig
);
    logic      prev_lvl;
    icap_pol_e pol;

    // Remember the last synchronized sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lvl <= 1'b0;
        end else begin
            prev_lvl <= level_in;
        end
    end

    // Decode the polarity and qualify the detected edge.
    always_comb begin
        pol  = pol_rise ? POL_RISE : POL_FALL;
        trig = enable & icap_edge_match(pol, prev_lvl, level_in);
    end
endmodule

// File: rtl/icap_store.sv
// Module: icap_store
// Holds the capture register and the capture flag.
// Assumes: trig is a single-cycle strobe; a capture outranks software actions.
module icap_store #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         trig,
    input  logic [W-1:0] cnt_val,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         clr,
    output logic [W-1:0] value,
    output logic         flag
);
    // Load the counter on capture, else accept a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (trig) begin
            value <= cnt_val;
        end else if (wr_en) begin
            value <= wr_data;
        end
    end

    // Set the flag on capture, else honour a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (trig) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/icap_unit.sv
// Module: icap_unit (top)
// Timer input capture: synchronizer, edge detector, register/flag, interrupt.
// Assumes: counter, prescaler and waveform logic live outside this block.
module icap_unit
    import icap_pkg::*;
#(
    parameter int unsigned CNT_W  = ICAP_CNT_W,
    parameter int unsigned STAGES = ICAP_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cap_pin,
    input  logic             edge_rise,
    input  logic             irq_en,
    input  logic             top_mode,
    input  logic             sw_wr_en,
    input  logic [CNT_W-1:0] sw_wr_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_reg,
    output logic             cap_flag,
    output logic             cap_irq
);
    logic pin_sync;
    logic cap_trig;

    icap_sync #(.STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cap_pin),
        .sync_out (pin_sync)
    );

    // Capture is disconnected while the register serves as TOP.
    icap_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (pin_sync),
        .pol_rise (edge_rise),
        .enable   (~top_mode),
        .trig     (cap_trig)
    );

    icap_store #(.W(CNT_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (cap_trig),
        .cnt_val (cnt_val),
        .wr_en   (sw_wr_en),
        .wr_data (sw_wr_data),
        .clr     (flag_clr),
        .value   (cap_reg),
        .flag    (cap_flag)
    );

    // Interrupt request is the flag qualified by its enable.
    assign cap_irq = cap_flag & irq_en;
endmodule

// File: rtl/icap_checker.sv
// Module: icap_checker
// Temporal properties of the capture unit, bound to every icap_unit instance.
// Assumes: sees the top ports plus the internal capture strobe.
module icap_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_val,
    input logic             irq_en,
    input logic             top_mode,
    input logic             sw_wr_en,
    input logic [CNT_W-1:0] sw_wr_data,
    input logic             flag_clr,
    input logic [CNT_W-1:0] cap_reg,
    input logic             cap_flag,
    input logic             cap_irq,
    input logic             cap_trig
);
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (cap_reg == '0 && !cap_flag)); // R1
    AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n) cap_trig |=> cap_reg == $past(cnt_val)); // R2
    AST_CAPTURE_FLAG: assert property (@(posedge clk) disable iff (!rst_n) cap_trig |=> cap_flag); // R4
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) cap_irq |-> (cap_flag && irq_en)); // R5
    AST_TOP_NO_SET: assert property (@(posedge clk) disable iff (!rst_n) (top_mode && !cap_flag) |=> !cap_flag); // R6
    AST_TOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (top_mode && !sw_wr_en) |=> $stable(cap_reg)); // R6
    AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (sw_wr_en && !cap_trig) |=> cap_reg == $past(sw_wr_data)); // R7
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n) (flag_clr && !cap_trig) |=> !cap_flag); // R8
endmodule

bind icap_unit icap_checker #(.CNT_W(CNT_W)) u_icap_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_val    (cnt_val),
    .irq_en     (irq_en),
    .top_mode   (top_mode),
    .sw_wr_en   (sw_wr_en),
    .sw_wr_data (sw_wr_data),
    .flag_clr   (flag_clr),
    .cap_reg    (cap_reg),
    .cap_flag   (cap_flag),
    .cap_irq    (cap_irq),
    .cap_trig   (cap_trig)
);

// File: tb/tb_icap_unit.sv
module tb_icap_unit;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt_val = '0;
    logic         cap_pin = 1'b0;
    logic         edge_rise = 1'b1;
    logic         irq_en = 1'b0;
    logic         top_mode = 1'b0;
    logic         sw_wr_en = 1'b0;
    logic [W-1:0] sw_wr_data = '0;
    logic         flag_clr = 1'b0;
    logic [W-1:0] cap_reg;
    logic         cap_flag;
    logic         cap_irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Reference model state (behavioural, from the requirements).
    logic         m_s1 = 1'b0, m_s2 = 1'b0, m_prev = 1'b0;
    logic [W-1:0] m_reg = '0;
    logic         m_flag = 1'b0;

    icap_unit dut (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cap_pin(cap_pin),
        .edge_rise(edge_rise), .irq_en(irq_en), .top_mode(top_mode),
        .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .flag_clr(flag_clr),
        .cap_reg(cap_reg), .cap_flag(cap_flag), .cap_irq(cap_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic edge_hit(logic rise, logic prev, logic curr);
        return rise ? (curr && !prev) : (!curr && prev);
    endfunction

    // Advance the reference model at every clock edge.
    always @(posedge clk) begin
        logic cap;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_reg = '0; m_flag = 0;
        end else begin
            cap = edge_hit(edge_rise, m_prev, m_s2) && !top_mode;
            if (cap) m_reg = cnt_val;
            else if (sw_wr_en) m_reg = sw_wr_data;
            if (cap) m_flag = 1'b1;
            else if (flag_clr) m_flag = 1'b0;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = cap_pin;
        end
    end

    task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic chk_model(string t_reg, string t_flag);
        chk(t_reg, cap_reg, m_reg);
        chk(t_flag, {15'd0, cap_flag}, {15'd0, m_flag});
        chk("R5", {15'd0, cap_irq}, {15'd0, m_flag && irq_en});
    endtask

    // Run n cycles: each negedge compares to the model.
    task automatic step(int n, string t_reg, string t_flag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk_model(t_reg, t_flag);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1CA9);
        // R1: reset state
        step(3, "R1", "R1");
        chk("R1", cap_reg, 16'h0000);
        chk("R1", {15'd0, cap_flag}, 16'h0);
        @(negedge clk); rst_n = 1'b1; irq_en = 1'b1;
        step(2, "R1", "R1");

        // R2: rising edge, counter held at 1234
        cnt_val = 16'h1234; cap_pin = 1'b1;
        step(2, "R2", "R4");
        chk("R2", {15'd0, cap_flag}, 16'h0);   // not yet captured
        step(1, "R2", "R4");
        chk("R2", cap_reg, 16'h1234);
        chk("R4", {15'd0, cap_flag}, 16'h1);
        chk("R5", {15'd0, cap_irq}, 16'h1);
        irq_en = 1'b0;
        step(1, "R5", "R5");
        chk("R5", {15'd0, cap_irq}, 16'h0);

        // R8: clear, then R3: falling pin while rising selected -> ignored
        flag_clr = 1'b1; step(1, "R8", "R8"); flag_clr = 1'b0;
        chk("R8", {15'd0, cap_flag}, 16'h0);
        cnt_val = 16'h5555; cap_pin = 1'b0;
        step(5, "R3", "R3");
        chk("R3", cap_reg, 16'h1234);
        chk("R3", {15'd0, cap_flag}, 16'h0);
        // R3: falling edge selected
        edge_rise = 1'b0; cap_pin = 1'b1; step(5, "R3", "R3");
        chk("R3", {15'd0, cap_flag}, 16'h0);
        cnt_val = 16'hBEEF; cap_pin = 1'b0; step(4, "R3", "R3");
        chk("R3", cap_reg, 16'hBEEF);
        chk("R3", {15'd0, cap_flag}, 16'h1);

        // R7/R8: capture coincides with software write and flag clear
        cnt_val = 16'hA5A5; cap_pin = 1'b1; step(4, "R7", "R8"); // rising, ignored
        cap_pin = 1'b0; step(2, "R7", "R8");
        sw_wr_en = 1'b1; sw_wr_data = 16'h0F0F; flag_clr = 1'b1;
        step(1, "R7", "R8");
        sw_wr_en = 1'b0; flag_clr = 1'b0;
        chk("R7", cap_reg, 16'hA5A5);
        chk("R8", {15'd0, cap_flag}, 16'h1);
        // R7: plain write
        sw_wr_en = 1'b1; sw_wr_data = 16'h3C3C; step(1, "R7", "R7"); sw_wr_en = 1'b0;
        chk("R7", cap_reg, 16'h3C3C);

        // R6: TOP mode blocks capture, write still loads
        top_mode = 1'b1; flag_clr = 1'b1; step(1, "R6", "R6"); flag_clr = 1'b0;
        cnt_val = 16'h7777; cap_pin = 1'b1; step(3, "R6", "R6");
        cap_pin = 1'b0; step(5, "R6", "R6");
        chk("R6", cap_reg, 16'h3C3C);
        chk("R6", {15'd0, cap_flag}, 16'h0);
        sw_wr_en = 1'b1; sw_wr_data = 16'h00FF; step(1, "R6", "R6"); sw_wr_en = 1'b0;
        chk("R6", cap_reg, 16'h00FF);
        top_mode = 1'b0;

        // Random phase, with one mid-run reset
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            chk_model("R2", "R4");
            cnt_val    = ($urandom % 16 == 0) ? W'($urandom) : cnt_val + 1'b1;
            if ($urandom % 4 == 0) cap_pin = ~cap_pin;
            if ($urandom % 50 == 0) edge_rise = ~edge_rise;
            if ($urandom % 40 == 0) top_mode = ~top_mode;
            if ($urandom % 10 == 0) irq_en = ~irq_en;
            sw_wr_en   = ($urandom % 8 == 0);
            sw_wr_data = W'($urandom);
            flag_clr   = ($urandom % 6 == 0);
            rst_n      = !(c >= 2000 && c < 2003);
        end
        step(2, "R2", "R4");
        finish_up();
    end
endmodule